// File: doc/BRIEF.md
# GPIO Interrupt Sense and Status Unit

This unit turns eight already-synchronised GPIO input lines into interrupt requests. Each line is given its own trigger condition: a level (active-high or active-low) or an edge (rising, falling, or any transition). Edge events are held in a sticky status bit until software clears them with a write-one-to-clear register. Level status has no storage. It simply mirrors whether the pin currently sits at its active level.

Software works through a byte-wide memory-mapped write port with a combinational read port, using 12-bit byte addresses. There are four configuration registers: level/edge selection, any-edge override, polarity, and enable. Two read-only status views are provided: raw and masked. A write-only clear register completes the set. Bit i of every register belongs to line i. A single interrupt output is the OR of all masked status bits. Register writes take effect at the clock edge where `bus_wr` is sampled high.

Top module: `gpio_irq_sense`

## Requirements
- R1: After reset, every configuration register reads 0, the raw and masked status read 0 while all pins are low, and `irq_out` is 0.
- R2: With the mode bit of a line at 1 (register 0x404, 1 = level), its raw status bit equals the pin when the polarity bit (0x40C) is 1 and equals the inverted pin when it is 0, in the same cycle the pin changes.
- R3: Writing ones to the clear register (0x41C) does not remove a level-mode status bit while its pin stays at the active level.
- R4: With mode 0 and any-edge bit (0x408) at 0, a polarity of 1 latches status on a 0-to-1 change of the pin and a polarity of 0 on a 1-to-0 change. An edge is a difference between the pin and its value one clock earlier, and the status is visible after that clock edge.
- R5: With mode 0 and the any-edge bit at 1, both pin transitions latch status, whatever the polarity bit holds.
- R6: A latched edge status stays set until a 1 is written to its bit of the clear register. Bits written as 0 leave their lines unchanged.
- R7: When an edge is detected on a line in the same cycle as a clear write to that line, the status stays set.
- R8: Masked status (0x418) equals raw status AND the enable register (0x410). `irq_out` is 1 exactly when any masked bit is 1.
- R9: Raw status (0x414) reports detected conditions whether or not the line is enabled.
- R10: The four configuration registers read back what was written. The clear register always reads 0. Writes to the raw and masked status addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 8 | Synchronised GPIO line values |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 12 | Byte address for reads and writes |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| irq_out | output | 1 | Combined interrupt request |

## Verification
A stuck or lost edge latch shows up at the raw-status address one clock after the pin transition that should have set it. A latch that fails to hold shows up on the next read after any idle cycle. A wrong polarity or mode decode in a level-mode line appears in the raw status and on `irq_out` within the same cycle the pin moves, because level status is combinational. A broken enable gating appears at once as a masked value or interrupt that disagrees with raw AND enable. The sweep runs every mode, override and polarity combination over rising and falling passes on every line, so each such fault surfaces within a few cycles of its stimulus.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // Byte offsets of the register port (12-bit address space)
  localparam logic [11:0] OFS_MODE = 12'h404;  // 1 = level, 0 = edge
  localparam logic [11:0] OFS_BOTH = 12'h408;  // 1 = any edge, polarity ignored
  localparam logic [11:0] OFS_POL  = 12'h40C;  // level high / rising edge when 1
  localparam logic [11:0] OFS_EN   = 12'h410;  // interrupt enable
  localparam logic [11:0] OFS_RAW  = 12'h414;  // raw status, read-only
  localparam logic [11:0] OFS_MSK  = 12'h418;  // masked status, read-only
  localparam logic [11:0] OFS_CLR  = 12'h41C;  // write one to clear edge status

  // Selected register, decoded from an address
  typedef enum logic [2:0] {
    SEL_NONE, SEL_MODE, SEL_BOTH, SEL_POL, SEL_EN, SEL_RAW, SEL_MSK, SEL_CLR
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [11:0] a);
    case (a)
      OFS_MODE: return SEL_MODE;
      OFS_BOTH: return SEL_BOTH;
      OFS_POL:  return SEL_POL;
      OFS_EN:   return SEL_EN;
      OFS_RAW:  return SEL_RAW;
      OFS_MSK:  return SEL_MSK;
      OFS_CLR:  return SEL_CLR;
      default:  return SEL_NONE;
    endcase
  endfunction

  // Level condition: active-high when pol is 1, active-low otherwise
  function automatic logic level_active(input logic pin, input logic pol);
    return pol ? pin : ~pin;
  endfunction

  // Edge condition from current and previous sample
  function automatic logic edge_event(input logic cur, input logic prev,
                                      input logic any_edge, input logic pol);
    logic rise;
    logic fall;
    rise = cur & ~prev;
    fall = ~cur & prev;
    if (any_edge) return rise | fall;
    return pol ? rise : fall;
  endfunction

endpackage

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  reg_sel_e          sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [LINES-1:0]  cfg_mode,
  output logic [LINES-1:0]  cfg_both,
  output logic [LINES-1:0]  cfg_pol,
  output logic [LINES-1:0]  cfg_ie,
  output logic [LINES-1:0]  clr_mask
);

  logic [LINES-1:0] wbits;
  assign wbits = wdata[LINES-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_mode <= '0;
      cfg_both <= '0;
      cfg_pol  <= '0;
      cfg_ie   <= '0;
    end else if (wr) begin
      case (sel)
        SEL_MODE: cfg_mode <= wbits;
        SEL_BOTH: cfg_both <= wbits;
        SEL_POL:  cfg_pol  <= wbits;
        SEL_EN:   cfg_ie   <= wbits;
        default: ;
      endcase
    end
  end

  // Clear strobe lasts only for the write cycle
  assign clr_mask = (wr && sel == SEL_CLR) ? wbits : '0;

endmodule

// File: rtl/gpio_irq_line.sv
module gpio_irq_line
  import gpio_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic mode_level,
  input  logic any_edge,
  input  logic pol,
  input  logic clr,
  output logic edge_hit,
  output logic raw
);

  logic prev_q;
  logic latch_q;

  assign edge_hit = ~mode_level & edge_event(pin, prev_q, any_edge, pol);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      prev_q <= pin;
      if (mode_level)    latch_q <= 1'b0;
      else if (edge_hit) latch_q <= 1'b1;  // a new edge beats a clear
      else if (clr)      latch_q <= 1'b0;
    end
  end

  assign raw = mode_level ? level_active(pin, pol) : latch_q;

endmodule

// File: rtl/gpio_irq_readmux.sv
module gpio_irq_readmux
  import gpio_irq_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int DATA_W = 8
) (
  input  reg_sel_e          sel,
  input  logic [LINES-1:0]  cfg_mode,
  input  logic [LINES-1:0]  cfg_both,
  input  logic [LINES-1:0]  cfg_pol,
  input  logic [LINES-1:0]  cfg_ie,
  input  logic [LINES-1:0]  raw_stat,
  input  logic [LINES-1:0]  masked_stat,
  output logic [DATA_W-1:0] rdata
);

  always_comb begin
    rdata = '0;
    case (sel)
      SEL_MODE: rdata[LINES-1:0] = cfg_mode;
      SEL_BOTH: rdata[LINES-1:0] = cfg_both;
      SEL_POL:  rdata[LINES-1:0] = cfg_pol;
      SEL_EN:   rdata[LINES-1:0] = cfg_ie;
      SEL_RAW:  rdata[LINES-1:0] = raw_stat;
      SEL_MSK:  rdata[LINES-1:0] = masked_stat;
      default:  rdata = '0;
    endcase
  end

endmodule

// File: rtl/gpio_irq_sense.sv
module gpio_irq_sense
  import gpio_irq_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  pin_in,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_out
);

  reg_sel_e         sel;
  logic [LINES-1:0] cfg_mode;
  logic [LINES-1:0] cfg_both;
  logic [LINES-1:0] cfg_pol;
  logic [LINES-1:0] cfg_ie;
  logic [LINES-1:0] clr_mask;
  logic [LINES-1:0] edge_hit;
  logic [LINES-1:0] raw_stat;
  logic [LINES-1:0] masked_stat;

  assign sel = decode_addr(12'(bus_addr));

  gpio_irq_regs #(.LINES(LINES), .DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (bus_wr),
    .sel      (sel),
    .wdata    (bus_wdata),
    .cfg_mode (cfg_mode),
    .cfg_both (cfg_both),
    .cfg_pol  (cfg_pol),
    .cfg_ie   (cfg_ie),
    .clr_mask (clr_mask)
  );

  for (genvar i = 0; i < LINES; i++) begin : g_line
    gpio_irq_line u_line (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin        (pin_in[i]),
      .mode_level (cfg_mode[i]),
      .any_edge   (cfg_both[i]),
      .pol        (cfg_pol[i]),
      .clr        (clr_mask[i]),
      .edge_hit   (edge_hit[i]),
      .raw        (raw_stat[i])
    );
  end

  assign masked_stat = raw_stat & cfg_ie;
  assign irq_out     = |masked_stat;

  gpio_irq_readmux #(.LINES(LINES), .DATA_W(DATA_W)) u_rmux (
    .sel         (sel),
    .cfg_mode    (cfg_mode),
    .cfg_both    (cfg_both),
    .cfg_pol     (cfg_pol),
    .cfg_ie      (cfg_ie),
    .raw_stat    (raw_stat),
    .masked_stat (masked_stat),
    .rdata       (bus_rdata)
  );

endmodule

// File: rtl/gpio_irq_sense_chk.sv
module gpio_irq_sense_chk
  import gpio_irq_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [LINES-1:0]  pin_in,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq_out,
  input logic [LINES-1:0]  cfg_mode,
  input logic [LINES-1:0]  cfg_pol,
  input logic [LINES-1:0]  cfg_ie,
  input logic [LINES-1:0]  clr_mask,
  input logic [LINES-1:0]  edge_hit,
  input logic [LINES-1:0]  raw_stat
);

  logic mode_wr;
  assign mode_wr = bus_wr && (12'(bus_addr) == OFS_MODE);

  AST_LEVEL_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_stat & cfg_mode) == ((pin_in ~^ cfg_pol) & cfg_mode)); // R2

  AST_EDGE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_hit != '0) && !mode_wr |=> ($past(edge_hit) & ~raw_stat) == '0); // R7

  AST_EDGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> ($past(raw_stat & ~cfg_mode) & ~raw_stat) == '0); // R6

  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_mask & ~cfg_mode & ~edge_hit) != '0
      |=> ($past(clr_mask & ~cfg_mode & ~edge_hit) & raw_stat) == '0); // R6

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> cfg_ie != '0); // R8

  AST_CLEAR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (12'(bus_addr) == OFS_CLR) |-> bus_rdata == '0); // R10

endmodule

bind gpio_irq_sense gpio_irq_sense_chk #(
  .LINES(LINES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pin_in    (pin_in),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .irq_out   (irq_out),
  .cfg_mode  (cfg_mode),
  .cfg_pol   (cfg_pol),
  .cfg_ie    (cfg_ie),
  .clr_mask  (clr_mask),
  .edge_hit  (edge_hit),
  .raw_stat  (raw_stat)
);

// File: tb/tb_gpio_irq_sense.sv
module tb_gpio_irq_sense;

  localparam logic [11:0] A_MODE = 12'h404;
  localparam logic [11:0] A_BOTH = 12'h408;
  localparam logic [11:0] A_POL  = 12'h40C;
  localparam logic [11:0] A_EN   = 12'h410;
  localparam logic [11:0] A_RAW  = 12'h414;
  localparam logic [11:0] A_MSK  = 12'h418;
  localparam logic [11:0] A_CLR  = 12'h41C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pin_in = 8'h00;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = 12'h000;
  logic [7:0]  bus_wdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic        irq_out;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  gpio_irq_sense dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_in    (pin_in),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out)
  );

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [7:0] acc;
    logic [7:0] exp_raw;
    logic [7:0] en;
    logic m, b, p;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    rd(A_MODE, d); check("R1", "mode reset", d, 8'h00);
    rd(A_BOTH, d); check("R1", "both reset", d, 8'h00);
    rd(A_POL,  d); check("R1", "pol reset",  d, 8'h00);
    rd(A_EN,   d); check("R1", "en reset",   d, 8'h00);
    rd(A_RAW,  d); check("R1", "raw reset",  d, 8'h00);
    rd(A_MSK,  d); check("R1", "msk reset",  d, 8'h00);
    check("R1", "irq reset", {7'd0, irq_out}, 8'h00);

    // Sweep every mode/override/polarity combination over all lines
    for (int c = 0; c < 8; c++) begin
      m = c[2]; b = c[1]; p = c[0];
      en = 8'hC3 ^ 8'(c * 8'h11);
      @(negedge clk); pin_in = 8'h00;
      wr(A_MODE, {8{m}});
      wr(A_BOTH, {8{b}});
      wr(A_POL,  {8{p}});
      wr(A_EN,   en);
      wr(A_CLR,  8'hFF);
      acc = 8'h00;
      for (int pass = 0; pass < 2; pass++) begin
        for (int i = 0; i < 8; i++) begin
          @(negedge clk);
          if (pass == 0) pin_in[i] = 1'b1; else pin_in[i] = 1'b0;
          if (m) begin
            exp_raw = p ? pin_in : ~pin_in;
            rd(A_RAW, d); check("R2", "level raw same cycle", d, exp_raw);
          end
          @(negedge clk);
          if (!m) begin
            if (b || (pass == 0 && p) || (pass == 1 && !p)) acc[i] = 1'b1;
            exp_raw = acc;
          end
          rd(A_RAW, d);
          check(m ? "R2" : (b ? "R5" : "R4"), "raw after step", d, exp_raw);
          rd(A_MSK, d); check("R8", "masked", d, exp_raw & en);
          check("R8", "irq", {7'd0, irq_out}, {7'd0, |(exp_raw & en)});
        end
      end
      if (!m) begin
        wr(A_CLR, 8'h0F);
        rd(A_RAW, d); check("R6", "partial clear", d, acc & 8'hF0);
        @(negedge clk);
        rd(A_RAW, d); check("R6", "latched holds", d, acc & 8'hF0);
      end
    end

    // R7: edge and clear in the same cycle
    @(negedge clk); pin_in = 8'h00;
    wr(A_MODE, 8'h00); wr(A_BOTH, 8'h00); wr(A_POL, 8'hFF); wr(A_EN, 8'hFF);
    wr(A_CLR, 8'hFF);
    @(negedge clk);
    pin_in = 8'h01; bus_wr = 1'b1; bus_addr = A_CLR; bus_wdata = 8'h01;
    @(negedge clk);
    bus_wr = 1'b0;
    rd(A_RAW, d); check("R7", "edge beats clear", d, 8'h01);
    wr(A_CLR, 8'h01);
    rd(A_RAW, d); check("R6", "clear after race", d, 8'h00);

    // R3: level status survives clear writes
    @(negedge clk); pin_in = 8'h10;
    wr(A_MODE, 8'hFF);
    wr(A_CLR, 8'hFF);
    rd(A_RAW, d); check("R3", "level not cleared", d, 8'h10);
    check("R3", "irq level", {7'd0, irq_out}, 8'h01);

    // R9: raw visible with enables off
    wr(A_EN, 8'h00);
    rd(A_RAW, d); check("R9", "raw with en=0", d, 8'h10);
    rd(A_MSK, d); check("R9", "masked with en=0", d, 8'h00);
    check("R9", "irq with en=0", {7'd0, irq_out}, 8'h00);

    // R10: readback, read-only status, clear reads zero
    wr(A_RAW, 8'hFF); wr(A_MSK, 8'hFF);
    rd(A_RAW, d); check("R10", "raw ignores write", d, 8'h10);
    rd(A_MSK, d); check("R10", "msk ignores write", d, 8'h00);
    wr(A_EN, 8'h3C);   rd(A_EN, d);   check("R10", "en readback", d, 8'h3C);
    wr(A_BOTH, 8'hA6); rd(A_BOTH, d); check("R10", "both readback", d, 8'hA6);
    wr(A_POL, 8'h59);  rd(A_POL, d);  check("R10", "pol readback", d, 8'h59);
    wr(A_MODE, 8'hC1); rd(A_MODE, d); check("R10", "mode readback", d, 8'hC1);
    rd(A_CLR, d); check("R10", "clear reads 0", d, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule